// File: doc/BRIEF.md
# Staged Multi-Group Unlock Controller

This controller sits beside a locked cipher core and releases its functional groups only after a two-level unlock. First, a sequence of three key patterns must arrive on a ten-bit key input on consecutive clock cycles. Any pattern that does not match sends the controller back to waiting for the first pattern. Once the controller is armed, it steps through nine read cycles. In each cycle it presents an address to an on-chip bit store and a challenge to a per-chip response block. Both answer within the same cycle.

Each cycle, the two-bit stored value is XOR-ed with the two-bit response to give two activation bits. Three consecutive cycles form one six-bit activation word per group. The groups are released in a fixed order: the substitution group first, then the inverse-substitution group, then the key-expansion group. A group's word appears on the outputs only once all three of its cycles are complete. After that, the word holds until reset. A done flag marks the end of the nine-cycle schedule.

Top module: `staged_unlock_ctrl`

## Requirements
- R1: While reset is low and right after it, every activation word is 0, `done_o` is 0, `rom_addr_o` is 0 and `chal_o` equals CHAL_BASE (default 9).
- R2: The controller arms when the patterns 0x2A5, 0x13C and 0x3C3 are present on `key_i` at three consecutive rising edges, in that order.
- R3: A pattern that differs from the expected one returns the matcher to waiting for the first pattern. No read cycle starts, and a later complete sequence still arms the controller.
- R4: In the cycle after the third pattern is accepted, the read schedule starts with `rom_addr_o` = 0. The address then rises by one per cycle up to 8. During each of these cycles `chal_o` = CHAL_BASE + `rom_addr_o`.
- R5: Each activation bit pair is `rom_bits_i` XOR `resp_i`, sampled in the cycle where it is addressed. Within a group, read slot k (k = 0, 1, 2) lands in word bits [2k+1:2k].
- R6: Group g occupies `grp_en_o[6g+5:6g]`. Group 0 (substitution) is built from steps 0-2, group 1 (inverse substitution) from steps 3-5, and group 2 (key expansion) from steps 6-8. Each word is 0 until the edge that ends its last step.
- R7: `done_o` rises at the edge that ends step 8, which is nine cycles after arming. From then on, `done_o` and all words hold until reset.
- R8: Once done, `rom_addr_o` stays 0. A new arming sequence on `key_i` changes no output.
- R9: `rom_addr_o` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| key_i | input | 10 | Key pattern input sampled every cycle |
| rom_addr_o | output | 4 | Read address of the stored activation bits |
| rom_bits_i | input | 2 | Stored bits at `rom_addr_o`, same cycle |
| chal_o | output | 5 | Challenge to the response block |
| resp_i | input | 2 | Response to `chal_o`, same cycle |
| grp_en_o | output | 18 | Three 6-bit activation words, group 0 in the low bits |
| done_o | output | 1 | All groups activated |

## Verification
The assertions rely on the bit store and the response block answering combinationally within the cycle in which they are addressed. The bench meets this by computing both from the current `rom_addr_o` and `chal_o` with continuous assignments. The assertions also assume that reset is only released at an edge where the key input does not complete the arming sequence. The bench drives the key to zero during reset and changes it only on falling edges. It varies the response table between runs so that the activation words differ from chip to chip.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_phase_e;
endpackage

// File: rtl/unlock_key_match.sv
module unlock_key_match #(
    parameter int KEY_W = 10,
    parameter int N_PAT = 3,
    parameter logic [N_PAT*KEY_W-1:0] ARM_KEYS = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [KEY_W-1:0] key_i,
    output logic             hit_o
);
    localparam int IDX_W = (N_PAT > 1) ? $clog2(N_PAT) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } match_t;

    match_t st_d, st_q;
    logic [KEY_W-1:0] want;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        want  = ARM_KEYS[st_q.idx*KEY_W +: KEY_W];
        if (key_i == want) begin
            if (st_q.idx == IDX_W'(N_PAT - 1)) begin
                hit_o      = 1'b1;
                st_d.idx   = '0;
            end else begin
                st_d.idx   = st_q.idx + 1'b1;
            end
        end else begin
            st_d.idx = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/unlock_sequencer.sv
module unlock_sequencer
    import unlock_pkg::*;
#(
    parameter int N_GRP     = 3,
    parameter int SLOTS     = 3,
    parameter int ADDR_W    = 4,
    parameter int CHAL_W    = 5,
    parameter int CHAL_BASE = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              run_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] step_o,
    output logic [CHAL_W-1:0] chal_o,
    output logic [$clog2(SLOTS)-1:0] slot_o,
    output logic [$clog2(N_GRP)-1:0] grp_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int GRP_W  = $clog2(N_GRP);

    typedef struct packed {
        seq_phase_e        ph;
        logic [ADDR_W-1:0] step;
        logic [SLOT_W-1:0] slot;
        logic [GRP_W-1:0]  grp;
    } seq_t;

    seq_t st_d, st_q;
    logic last_step;

    always_comb begin
        st_d      = st_q;
        last_step = (st_q.slot == SLOT_W'(SLOTS - 1)) && (st_q.grp == GRP_W'(N_GRP - 1));
        unique case (st_q.ph)
            SEQ_IDLE: begin
                if (start_i) begin
                    st_d.ph   = SEQ_RUN;
                    st_d.step = '0;
                    st_d.slot = '0;
                    st_d.grp  = '0;
                end
            end
            SEQ_RUN: begin
                if (last_step) begin
                    st_d.ph   = SEQ_DONE;
                    st_d.step = '0;
                    st_d.slot = '0;
                    st_d.grp  = '0;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                    if (st_q.slot == SLOT_W'(SLOTS - 1)) begin
                        st_d.slot = '0;
                        st_d.grp  = st_q.grp + 1'b1;
                    end else begin
                        st_d.slot = st_q.slot + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{ph: SEQ_IDLE, step: '0, slot: '0, grp: '0};
        else         st_q <= st_d;
    end

    assign run_o  = (st_q.ph == SEQ_RUN);
    assign done_o = (st_q.ph == SEQ_DONE);
    assign step_o = st_q.step;
    assign slot_o = st_q.slot;
    assign grp_o  = st_q.grp;
    assign chal_o = CHAL_W'(CHAL_BASE) + CHAL_W'(st_q.step);
endmodule

// File: rtl/unlock_word_bank.sv
module unlock_word_bank #(
    parameter int N_GRP = 3,
    parameter int SLOTS = 3,
    parameter int RW    = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     run_i,
    input  logic [$clog2(SLOTS)-1:0] slot_i,
    input  logic [$clog2(N_GRP)-1:0] grp_i,
    input  logic [RW-1:0]            stored_i,
    input  logic [RW-1:0]            resp_i,
    output logic [N_GRP*SLOTS*RW-1:0] words_o
);
    localparam int GW     = SLOTS * RW;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int GRP_W  = $clog2(N_GRP);

    typedef struct packed {
        logic [GW-1:0]       acc;
        logic [N_GRP*GW-1:0] words;
    } bank_t;

    bank_t st_d, st_q;
    logic [RW-1:0] pair;
    logic [GW-1:0] full;
    logic          close_grp;
    logic [N_GRP-1:0] load;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_load
            assign load[g] = run_i && close_grp && (grp_i == GRP_W'(g));
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        pair      = stored_i ^ resp_i;
        full      = st_q.acc;
        full[slot_i*RW +: RW] = pair;
        close_grp = (slot_i == SLOT_W'(SLOTS - 1));
        if (run_i) st_d.acc = full;
        for (int g = 0; g < N_GRP; g++) begin
            if (load[g]) st_d.words[g*GW +: GW] = full;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign words_o = st_q.words;
endmodule

// File: rtl/staged_unlock_ctrl.sv
module staged_unlock_ctrl #(
    parameter int KEY_W     = 10,
    parameter int N_PAT     = 3,
    parameter logic [N_PAT*KEY_W-1:0] ARM_KEYS = {10'h3C3, 10'h13C, 10'h2A5},
    parameter int N_GRP     = 3,
    parameter int SLOTS     = 3,
    parameter int RW        = 2,
    parameter int CHAL_W    = 5,
    parameter int CHAL_BASE = 9,
    parameter int ADDR_W    = $clog2(N_GRP * SLOTS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [KEY_W-1:0]          key_i,
    output logic [ADDR_W-1:0]         rom_addr_o,
    input  logic [RW-1:0]             rom_bits_i,
    output logic [CHAL_W-1:0]         chal_o,
    input  logic [RW-1:0]             resp_i,
    output logic [N_GRP*SLOTS*RW-1:0] grp_en_o,
    output logic                      done_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int GRP_W  = $clog2(N_GRP);

    logic              armed;
    logic              run;
    logic [SLOT_W-1:0] slot;
    logic [GRP_W-1:0]  grp;

    unlock_key_match #(
        .KEY_W(KEY_W), .N_PAT(N_PAT), .ARM_KEYS(ARM_KEYS)
    ) u_match (
        .clk_i(clk_i), .rst_ni(rst_ni), .key_i(key_i), .hit_o(armed)
    );

    unlock_sequencer #(
        .N_GRP(N_GRP), .SLOTS(SLOTS), .ADDR_W(ADDR_W),
        .CHAL_W(CHAL_W), .CHAL_BASE(CHAL_BASE)
    ) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(armed),
        .run_o(run), .done_o(done_o), .step_o(rom_addr_o),
        .chal_o(chal_o), .slot_o(slot), .grp_o(grp)
    );

    unlock_word_bank #(
        .N_GRP(N_GRP), .SLOTS(SLOTS), .RW(RW)
    ) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
        .slot_i(slot), .grp_i(grp),
        .stored_i(rom_bits_i), .resp_i(resp_i),
        .words_o(grp_en_o)
    );
endmodule

// File: rtl/staged_unlock_ctrl_chk.sv
module staged_unlock_ctrl_chk #(
    parameter int N_GRP  = 3,
    parameter int SLOTS  = 3,
    parameter int RW     = 2,
    parameter int ADDR_W = 4
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [ADDR_W-1:0]         rom_addr_o,
    input logic [N_GRP*SLOTS*RW-1:0] grp_en_o,
    input logic                      done_o
);
    localparam int N_STEPS = N_GRP * SLOTS;
    localparam int GW      = SLOTS * RW;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_STEPS - 1);

    assert_addr_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, rom_addr_o} <= {1'b0, LAST});

    assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rom_addr_o != '0 && rom_addr_o != LAST) |=> rom_addr_o == $past(rom_addr_o) + 1'b1);

    assert_last_group_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> grp_en_o[(N_GRP-1)*GW +: GW] == '0);

    assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> done_o);

    assert_words_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> $stable(grp_en_o));

    assert_done_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(rom_addr_o) == LAST);

    assert_addr_parked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> rom_addr_o == '0);
endmodule

bind staged_unlock_ctrl staged_unlock_ctrl_chk #(
    .N_GRP(N_GRP), .SLOTS(SLOTS), .RW(RW), .ADDR_W(ADDR_W)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .rom_addr_o(rom_addr_o),
    .grp_en_o(grp_en_o), .done_o(done_o)
);

// File: tb/test_staged_unlock_ctrl.sv
module test_staged_unlock_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CBASE = 9;
    localparam logic [9:0] P0 = 10'h2A5, P1 = 10'h13C, P2 = 10'h3C3;

    typedef struct packed {
        logic [9:0] k0;
        logic [9:0] k1;
        logic [9:0] k2;
        logic       arms;
        logic [1:0] seed;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{P0, P1, P2, 1'b1, 2'd0},
        '{P0, 10'h000, P2, 1'b0, 2'd1},
        '{10'h2A4, P1, P2, 1'b0, 2'd2},
        '{P0, P1, 10'h3C2, 1'b0, 2'd3},
        '{P0, P1, P2, 1'b1, 2'd2},
        '{P1, P0, P2, 1'b0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  key = '0;
    logic [1:0]  seed = '0;
    logic [3:0]  rom_addr;
    logic [1:0]  rom_bits, resp;
    logic [4:0]  chal;
    logic [17:0] grp_en;
    logic        done;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] rom_fn(int a);
        return 2'((a * 3 + 1) ^ (a >> 2));
    endfunction

    function automatic logic [1:0] resp_fn(int c, int s);
        return 2'((c + (c >> 2)) ^ s);
    endfunction

    function automatic logic [5:0] exp_word(int g, int s);
        logic [5:0] w;
        for (int k = 0; k < 3; k++)
            w[2*k +: 2] = rom_fn(g*3 + k) ^ resp_fn(CBASE + g*3 + k, s);
        return w;
    endfunction

    assign rom_bits = rom_fn(int'(rom_addr));
    assign resp     = resp_fn(int'(chal), int'(seed));

    staged_unlock_ctrl i_staged_unlock_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .key_i(key),
        .rom_addr_o(rom_addr), .rom_bits_i(rom_bits),
        .chal_o(chal), .resp_i(resp),
        .grp_en_o(grp_en), .done_o(done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        key   = '0;
        repeat (2) @(negedge clk);
        chk("R1 words", 32'(grp_en), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 addr", 32'(rom_addr), 0);
        chk("R1 chal", 32'(chal), CBASE);
        rst_n = 1'b1;
    endtask

    task automatic drive3(logic [9:0] a, logic [9:0] b, logic [9:0] c);
        @(negedge clk) key = a;
        @(negedge clk) key = b;
        @(negedge clk) key = c;
        @(negedge clk) key = '0;
    endtask

    // called at the falling edge right after the third pattern edge
    task automatic observe(logic armed, int s);
        for (int j = 0; j < 12; j++) begin
            if (j > 0) @(negedge clk);
            if (armed) begin
                if (j < 9) begin
                    chk("R4 addr", 32'(rom_addr), j);
                    chk("R4 chal", 32'(chal), CBASE + j);
                end else begin
                    chk("R8 addr parked", 32'(rom_addr), 0);
                end
                for (int g = 0; g < 3; g++)
                    chk("R5 R6 word", 32'(grp_en[g*6 +: 6]),
                        (g*3 + 3 <= j) ? 32'(exp_word(g, s)) : 0);
                chk("R7 done", 32'(done), (j >= 9) ? 1 : 0);
            end else begin
                chk("R3 addr idle", 32'(rom_addr), 0);
                chk("R3 words idle", 32'(grp_en), 0);
                chk("R3 done idle", 32'(done), 0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // table walk: R2 arming, R3 rejection, R5 per-seed words
        for (int v = 0; v < 6; v++) begin
            seed = VECS[v].seed;
            do_reset();
            drive3(VECS[v].k0, VECS[v].k1, VECS[v].k2);
            observe(VECS[v].arms, int'(VECS[v].seed));
        end

        // R3: wrong third pattern, then a full sequence still arms
        seed = 2'd1;
        do_reset();
        @(negedge clk) key = P0;
        @(negedge clk) key = P1;
        @(negedge clk) key = P0;
        @(negedge clk) key = '0;
        chk("R3 no start after wrong key", 32'(rom_addr), 0);
        chk("R3 no words after wrong key", 32'(grp_en), 0);
        drive3(P0, P1, P2);
        observe(1'b1, 1);

        // R8: re-arming after done changes nothing
        begin
            logic [17:0] held;
            held = grp_en;
            drive3(P0, P1, P2);
            for (int j = 0; j < 5; j++) begin
                chk("R8 words held", 32'(grp_en), 32'(held));
                chk("R8 addr", 32'(rom_addr), 0);
                chk("R7 done held", 32'(done), 1);
                @(negedge clk);
            end
        end

        // R1: reset in the middle of the schedule clears everything
        seed = 2'd3;
        do_reset();
        drive3(P0, P1, P2);
        repeat (4) @(negedge clk);
        chk("R6 group0 loaded mid-run", 32'(grp_en[5:0]), 32'(exp_word(0, 3)));
        do_reset();
        @(negedge clk);
        chk("R1 words after mid reset", 32'(grp_en), 0);
        chk("R1 addr after mid reset", 32'(rom_addr), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule